// File: doc/BRIEF.md
# Iterative Multiply/Divide Step Sequencer

This block runs one unsigned 32-bit multiply or divide over many clock cycles. A start pulse, sampled while the block is idle, captures three operand words and the kind of operation. From then on a microcycle counter advances once per clock. In each cycle the block drives an ALU operation code, three operand-stack offsets (two source slots and one destination slot with its write enable) and a stack-pointer delta, so that a surrounding stack machine can follow the schedule. In the last cycle it raises an end signal, which the surrounding machine uses to fetch the next instruction.

A small shift-add / shift-subtract datapath with an accumulator and an MQ register sits inside the block, so it can be checked alone. A multiply takes one load cycle, sixteen steps that each retire two multiplier bits, and one readout cycle. A divide takes one range-check cycle, one load cycle, thirty-two one-bit restoring steps and one readout cycle that pops the stack. If the dividend's high word is not below the divisor, the range check raises a divide-check trap and abandons the operation. Stack storage and trap handling live outside the block.

Top module: `muldiv_seq`

## Requirements
- R1: After reset, and in every idle cycle, busy, done and div_trap are 0, alu_op is 0 (no operation) and sp_delta is 0. A reset in the middle of an operation returns the block to idle.
- R2: A start seen at a clock edge while idle sets busy from the next cycle. busy stays 1 through the end cycle (done=1) or the trap cycle, and is 0 in the cycle after it. done is high for exactly one cycle.
- R3: Multiply (op_div=0) schedule, counted from microcycle 0: cycle 0 has alu_op 1 (load MQ) with b_off=-1, c_off=-1. Cycles 1..16 have alu_op 2 (multiply step) with a_off=-1, b_off=0, c_off=-1. Cycle 17 has alu_op 4 (read MQ), c_off=0 and done=1. Offsets are 3-bit two's complement.
- R4: After a multiply ends, res_hi:res_lo holds the 64-bit unsigned product word_a*word_b.
- R5: Divide (op_div=1) cycle 0 has alu_op 5 (range check) with a_off=-2, b_off=0. When word_a >= word_b (unsigned, so a zero divisor also counts), div_trap is 1 in that cycle, busy is 0 in the next cycle and done never rises. Otherwise div_trap stays 0.
- R6: Divide schedule: cycle 1 has alu_op 1 with a_off=-2, b_off=-1, c_off=-1. Cycles 2..33 have alu_op 3 (divide step) with a_off=-1, b_off=0, c_off=-1. Cycle 34 has alu_op 4, c_off=-2, sp_delta=-1 (2'b11) and done=1. sp_delta is 0 in every other cycle.
- R7: After a divide ends, res_lo holds the quotient and res_hi the remainder of {word_a, word_l} / word_b.
- R8: A start raised while busy is ignored. The running operation keeps its kind, its operands, its end cycle and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| word_a | input | W | Multiplier, or dividend high word |
| word_l | input | W | Dividend low word (unused by multiply) |
| word_b | input | W | Multiplicand, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End cycle: fetch next instruction |
| div_trap | output | 1 | Divide range check failed |
| ucyc | output | CW | Current microcycle number |
| alu_op | output | 3 | ALU operation code for this cycle |
| a_off | output | 3 | First source stack offset |
| b_off | output | 3 | Second source stack offset |
| c_off | output | 3 | Destination stack offset |
| c_wr | output | 1 | Destination write enable |
| sp_delta | output | 2 | Stack-pointer change, two's complement |
| res_hi | output | W | Accumulator: product high / remainder |
| res_lo | output | W | MQ: product low / quotient |

## Verification
The hardest situation to reach is a second start arriving partway through a running operation, with a different kind and different operands. Only a stray start pulse timed to a chosen microcycle can create it. The bench raises start at microcycle 5 of a multiply with divide operands on the inputs, then confirms that the end still comes at cycle 17 with the original product. The trap boundary is reached with a dividend high word exactly equal to the divisor and with a zero divisor, next to a case one below the limit that must not trap.

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_div,
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_l,
  input  logic [W-1:0]  word_b,
  output logic          busy,
  output logic          done,
  output logic          div_trap,
  output logic [CW-1:0] ucyc,
  output logic [2:0]    alu_op,
  output logic [2:0]    a_off,
  output logic [2:0]    b_off,
  output logic [2:0]    c_off,
  output logic          c_wr,
  output logic [1:0]    sp_delta,
  output logic [W-1:0]  res_hi,
  output logic [W-1:0]  res_lo
);
  localparam int MUL_LAST = W / 2 + 1;
  localparam int DIV_LAST = W + 2;
  localparam logic [2:0] OP_NOP = 3'd0, OP_LDMQ = 3'd1, OP_MSTEP = 3'd2,
                         OP_DSTEP = 3'd3, OP_RDMQ = 3'd4, OP_CHK = 3'd5;
  localparam logic [2:0] M1 = 3'b111, M2 = 3'b110;

  logic         is_div;
  logic [W-1:0] x_q, l_q, d_q, acc, mq;
  logic [W+1:0] msum;
  logic [W-1:0] dsub;
  logic         dfit;

  assign msum = {2'b00, acc}
              + (mq[0] ? {2'b00, d_q} : '0)
              + (mq[1] ? {1'b0, d_q, 1'b0} : '0);
  assign dfit = {acc, mq[W-1]} >= {1'b0, d_q};
  assign dsub = W'({acc, mq[W-1]} - {1'b0, d_q});
  assign res_hi = acc;
  assign res_lo = mq;

  always_comb begin
    alu_op = OP_NOP; a_off = '0; b_off = '0; c_off = '0;
    c_wr = 1'b0; sp_delta = 2'b00; done = 1'b0; div_trap = 1'b0;
    if (busy) begin
      if (!is_div) begin
        if (ucyc == '0) begin
          alu_op = OP_LDMQ; b_off = M1; c_off = M1; c_wr = 1'b1;
        end else if (ucyc == CW'(MUL_LAST)) begin
          alu_op = OP_RDMQ; c_wr = 1'b1; done = 1'b1;
        end else begin
          alu_op = OP_MSTEP; a_off = M1; c_off = M1; c_wr = 1'b1;
        end
      end else begin
        if (ucyc == '0) begin
          alu_op = OP_CHK; a_off = M2;
          div_trap = x_q >= d_q;
        end else if (ucyc == CW'(1)) begin
          alu_op = OP_LDMQ; a_off = M2; b_off = M1; c_off = M1; c_wr = 1'b1;
        end else if (ucyc == CW'(DIV_LAST)) begin
          alu_op = OP_RDMQ; c_off = M2; c_wr = 1'b1; sp_delta = 2'b11;
          done = 1'b1;
        end else begin
          alu_op = OP_DSTEP; a_off = M1; c_off = M1; c_wr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; is_div <= 1'b0; ucyc <= '0;
      x_q <= '0; l_q <= '0; d_q <= '0; acc <= '0; mq <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; is_div <= op_div; ucyc <= '0;
        x_q <= word_a; l_q <= word_l; d_q <= word_b;
      end
    end else begin
      case (alu_op)
        OP_LDMQ: begin
          acc <= is_div ? x_q : '0;
          mq  <= is_div ? l_q : x_q;
        end
        OP_MSTEP: begin
          acc <= msum[W+1:2];
          mq  <= {msum[1:0], mq[W-1:2]};
        end
        OP_DSTEP: begin
          acc <= dfit ? dsub : {acc[W-2:0], mq[W-1]};
          mq  <= {mq[W-2:0], dfit};
        end
        default: ;
      endcase
      if (done || div_trap) busy <= 1'b0;
      ucyc <= ucyc + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (alu_op == OP_NOP && !done && !div_trap && sp_delta == 2'b00));

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !div_trap) |=> busy);

  p_ends_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done || div_trap) |=> !busy);

  p_cycle_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !div_trap) |=> ucyc == $past(ucyc) + 1'b1);

  p_trap_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_trap |-> (busy && is_div && ucyc == '0));

  p_pop_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_delta != 2'b00) |-> (done && is_div));

  p_kind_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !div_trap) |=> ($stable(is_div) && $stable(d_q)));
endmodule

// File: tb/muldiv_seq_tb_top.sv
`timescale 1ns/1ps
module muldiv_seq_tb_top;
  localparam int W = 32;
  localparam int CW = $clog2(W + 3);
  localparam int NV = 11;
  // {op_div, word_a, word_l, word_b}
  localparam logic [3*W:0] VEC [NV] = '{
    {1'b0, 32'h0000_0003, 32'h0, 32'h0000_0005},
    {1'b0, 32'h0000_0000, 32'h0, 32'hdead_beef},
    {1'b0, 32'hffff_ffff, 32'h0, 32'hffff_ffff},
    {1'b0, 32'h1234_5678, 32'h0, 32'h9abc_def0},
    {1'b0, 32'h8000_0000, 32'h0, 32'h0000_0001},
    {1'b1, 32'h0000_0000, 32'h0000_0064, 32'h0000_0007},
    {1'b1, 32'h0000_0001, 32'h0000_0000, 32'h0000_0002},
    {1'b1, 32'hffff_fffe, 32'hffff_ffff, 32'hffff_ffff},
    {1'b1, 32'h0000_1234, 32'h5678_9abc, 32'h0001_0000},
    {1'b1, 32'h0000_0005, 32'h0000_0000, 32'h0000_0005},
    {1'b1, 32'h0000_0000, 32'h0000_0009, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_div = 1'b0;
  logic [W-1:0] word_a = '0, word_l = '0, word_b = '0;
  logic busy, done, div_trap, c_wr;
  logic [CW-1:0] ucyc;
  logic [2:0] alu_op, a_off, b_off, c_off;
  logic [1:0] sp_delta;
  logic [W-1:0] res_hi, res_lo;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  muldiv_seq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .word_a(word_a), .word_l(word_l), .word_b(word_b),
    .busy(busy), .done(done), .div_trap(div_trap), .ucyc(ucyc),
    .alu_op(alu_op), .a_off(a_off), .b_off(b_off), .c_off(c_off),
    .c_wr(c_wr), .sp_delta(sp_delta), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_op(input logic dv, input int n);
    if (!dv) return (n == 0) ? 3'd1 : (n == 17) ? 3'd4 : 3'd2;
    return (n == 0) ? 3'd5 : (n == 1) ? 3'd1 : (n == 34) ? 3'd4 : 3'd3;
  endfunction

  task automatic run(input logic dv, input logic [W-1:0] a, l, b, input int inj);
    logic [63:0] num, e_hi, e_lo;
    int n = 0;
    int last = dv ? 34 : 17;
    logic trap = dv && (a >= b);
    if (!dv) begin
      num = {32'h0, a} * {32'h0, b};
      e_hi = {32'h0, num[63:32]}; e_lo = {32'h0, num[31:0]};
    end else if (!trap) begin
      num = {a, l};
      e_lo = num / {32'h0, b}; e_hi = num % {32'h0, b};
    end
    @(negedge clk);
    op_div = dv; word_a = a; word_l = l; word_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {63'h0, busy}, 64'h1);
    if (dv) begin
      chk("R5 check op", {61'h0, alu_op}, 64'h5);
      chk("R5 check a_off", {61'h0, a_off}, 64'h6);
      chk("R5 check b_off", {61'h0, b_off}, 64'h0);
      chk("R5 trap flag", {63'h0, div_trap}, {63'h0, trap});
    end
    if (trap) begin
      @(negedge clk);
      chk("R5 trap releases busy", {63'h0, busy}, 64'h0);
      chk("R5 no done after trap", {63'h0, done}, 64'h0);
      return;
    end
    while (!done && n < 60) begin
      chk(dv ? "R6 schedule op" : "R3 schedule op", {61'h0, alu_op}, {61'h0, exp_op(dv, n)});
      chk(dv ? "R6 sp_delta zero" : "R3 sp_delta zero", {62'h0, sp_delta}, 64'h0);
      if (!dv && n == 0) chk("R3 load offsets", {55'h0, a_off, b_off, c_off}, {55'h0, 3'd0, 3'b111, 3'b111});
      if (!dv && n == 5) chk("R3 step offsets", {55'h0, a_off, b_off, c_off}, {55'h0, 3'b111, 3'd0, 3'b111});
      if (dv && n == 1) chk("R6 load offsets", {55'h0, a_off, b_off, c_off}, {55'h0, 3'b110, 3'b111, 3'b111});
      if (dv && n == 20) chk("R6 step offsets", {55'h0, a_off, b_off, c_off}, {55'h0, 3'b111, 3'd0, 3'b111});
      if (n == inj) begin
        start = 1'b1; op_div = ~dv; word_a = 32'h0000_0001; word_l = 32'h1; word_b = 32'h7;
      end
      if (n == inj + 1) start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(dv ? "R6 end cycle" : "R3 end cycle", n, last);
    chk(dv ? "R6 end op" : "R3 end op", {61'h0, alu_op}, 64'h4);
    chk(dv ? "R6 end c_off" : "R3 end c_off", {61'h0, c_off}, dv ? 64'h6 : 64'h0);
    chk(dv ? "R6 end sp_delta" : "R3 end sp_delta", {62'h0, sp_delta}, dv ? 64'h3 : 64'h0);
    chk("R2 busy in end cycle", {63'h0, busy}, 64'h1);
    @(negedge clk);
    chk("R2 busy drops", {63'h0, busy}, 64'h0);
    chk("R2 done single", {63'h0, done}, 64'h0);
    chk(inj >= 0 ? "R8 result hi kept" : (dv ? "R7 remainder" : "R4 product hi"), {32'h0, res_hi}, e_hi);
    chk(inj >= 0 ? "R8 result lo kept" : (dv ? "R7 quotient" : "R4 product lo"), {32'h0, res_lo}, e_lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {63'h0, busy}, 64'h0);
    chk("R1 reset op", {61'h0, alu_op}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done/trap", {62'h0, done, div_trap}, 64'h0);
    chk("R1 idle sp_delta", {62'h0, sp_delta}, 64'h0);
    for (int i = 0; i < NV; i++)
      run(VEC[i][3*W], VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], -10);
    // R8: stray start of another kind during a multiply and during a divide
    run(1'b0, 32'h0001_0001, 32'h0, 32'h0000_ffff, 5);
    run(1'b1, 32'h0000_0003, 32'h0000_0010, 32'h0000_0009, 7);
    // R5 boundary: one below the limit does not trap
    run(1'b1, 32'h0000_0004, 32'hffff_ffff, 32'h0000_0005, -10);
    // R1: reset in the middle of a divide
    @(negedge clk);
    op_div = 1'b1; word_a = 32'h0; word_l = 32'h55; word_b = 32'h3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset busy", {63'h0, busy}, 64'h0);
    chk("R1 mid-run reset op", {61'h0, alu_op}, 64'h0);
    rst_n = 1'b1;
    run(1'b0, 32'h0000_0007, 32'h0, 32'h0000_0006, -10);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule